// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with Write-Through

This block is a small data cache that sits between a requester and a slower line-oriented memory. Each set holds two lines, one per way, and each line carries its own valid flag and tag. A request's address is cut into a tag, a set index and a word/byte position. The selected set's two tags are checked against the request tag at the same moment. A match in either way is a hit, and the matching way's word is steered to the read data.

A read that misses fetches the whole line from memory, installs it and returns the requested word. The refill goes into an empty way of the set if one exists. Otherwise it goes into the way that was used least recently, tracked by one bit per set. Writes always pass through to memory. A write that hits also updates the cached word. A write that misses leaves the cache unchanged. Only one request is in flight at a time, and the requester sees this as a ready signal that drops while a memory transaction is outstanding.

Top module: `assoc2_cache`

## Requirements
- R1: Address split (defaults: 16-byte lines, 64 sets, 32-bit words). Bits [3:0] are the line offset, [9:4] the set index and [31:10] the tag. Bits [3:2] pick the 32-bit word in the line (word k is line bits [32k+31:32k]), and bits [1:0] are ignored. Two addresses differing in any tag bit, including bit 31, never alias.
- R2: After reset every line is invalid. req_ready is 1, resp_valid is 0 and mem_req is 0, and the first read of any address misses.
- R3: A read hit gives resp_valid=1 and resp_hit=1 with the matching way's word exactly one cycle after acceptance, and issues no memory transaction.
- R4: Hit is the OR of the two valid-gated tag matches. Two lines with different tags can live in the same set and both hit. Both ways never match at once.
- R5: A read miss raises mem_req with mem_we=0 on the next cycle, with mem_addr line-aligned (offset bits zero). The request is held stable until mem_ack. One cycle after the ack edge the block gives resp_valid=1, resp_hit=0 and the requested word of mem_rline.
- R6: On a refill, an invalid way is chosen first (way 0 before way 1). If both ways are valid, the least recently used way is chosen.
- R7: Every hit, read or write, and every refill sets the set's LRU state to point at the other way.
- R8: A write hit updates the word in the matching way and is forwarded to memory with mem_we=1, mem_addr equal to the request address with bits [1:0] cleared, and mem_wdata. The response comes one cycle after mem_ack with resp_hit=1, and later reads return the new word.
- R9: A write miss is forwarded to memory the same way but allocates nothing. Its response has resp_hit=0, and a later read of that address misses.
- R10: req_ready is 0 while a memory transaction is outstanding. Requests presented then are ignored: nothing is written and nothing is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write word |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | 32 | Read word (zero for writes) |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Memory transaction is a word write |
| mem_addr | output | 32 | Line address (read) or word address (write) |
| mem_wdata | output | 32 | Word to write to memory |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_rline | input | 128 | Line returned by memory on a read ack |

## Verification
A read hit is due on the cycle right after the edge that accepts it. The bench samples at the next falling edge and checks that this is exactly one cycle later and that no memory acknowledge occurred. Misses and writes are due one cycle after the acknowledge edge. The memory model in the bench records the cycle it raises mem_ack, waits a random 0 to 3 cycles before doing so, and the bench requires the response exactly one cycle after that. Hit and miss outcomes and returned words come from a bench-side tag/valid/LRU model and a memory image. Because writes pass through, cached data always equals memory.

// File: rtl/cache_pkg.sv
package cache_pkg;

    localparam int NWAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WTHRU = 2'd2
    } cstate_e;

endpackage

// File: rtl/way_store.sv
module way_store #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 22,
    parameter int LINE_W = 128,
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic                       rd_vld,
    output logic [TAG_W-1:0]           rd_tag,
    output logic [LINE_W-1:0]          rd_line,
    input  logic                       fill_en,
    input  logic [IDX_W-1:0]           fill_idx,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic [LINE_W-1:0]          fill_line,
    input  logic                       upd_en,
    input  logic [IDX_W-1:0]           upd_idx,
    input  logic [$clog2(LINE_W/WORD_W)-1:0] upd_sel,
    input  logic [WORD_W-1:0]          upd_word
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   vld_d, vld_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];

    always_comb begin
        vld_d = vld_q;
        if (fill_en) begin
            vld_d[fill_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    // storage arrays carry no reset; the valid bits guard them
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            line_q[fill_idx] <= fill_line;
        end else if (upd_en) begin
            line_q[upd_idx][upd_sel*WORD_W +: WORD_W] <= upd_word;
        end
    end

    assign rd_vld  = vld_q[rd_idx];
    assign rd_tag  = tag_q[rd_idx];
    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/tag_match.sv
module tag_match #(
    parameter int TAG_W  = 22,
    parameter int LINE_W = 128,
    parameter int WORD_W = 32
) (
    input  logic [1:0]                         way_vld,
    input  logic [1:0][TAG_W-1:0]              way_tag,
    input  logic [1:0][LINE_W-1:0]             way_line,
    input  logic [TAG_W-1:0]                   req_tag,
    input  logic [$clog2(LINE_W/WORD_W)-1:0]   word_sel,
    output logic [1:0]                         match,
    output logic                               hit,
    output logic [WORD_W-1:0]                  hit_word
);
    logic [1:0][WORD_W-1:0] way_word;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w]    = way_vld[w] && (way_tag[w] == req_tag);
        assign way_word[w] = way_line[w][word_sel*WORD_W +: WORD_W];
    end

    // AND-OR select steered by the match lines
    always_comb begin
        hit_word = '0;
        for (int w = 0; w < 2; w++) begin
            hit_word = hit_word | ({WORD_W{match[w]}} & way_word[w]);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/victim_pick.sv
module victim_pick (
    input  logic [1:0] way_vld,
    input  logic       lru_way,
    output logic       victim
);
    always_comb begin
        if (!way_vld[0]) begin
            victim = 1'b0;
        end else if (!way_vld[1]) begin
            victim = 1'b1;
        end else begin
            victim = lru_way;
        end
    end
endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SET_COUNT  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [WORD_W-1:0]          req_wdata,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output logic [WORD_W-1:0]          resp_rdata,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [WORD_W-1:0]          mem_wdata,
    input  logic                       mem_ack,
    input  logic [LINE_BYTES*8-1:0]    mem_rline
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SET_COUNT);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFF_W - BSEL_W;

    typedef struct packed {
        cstate_e              state;
        logic [ADDR_W-1:0]    addr;
        logic [WORD_W-1:0]    wdata;
        logic                 was_hit;
        logic                 victim;
        logic [SET_COUNT-1:0] lru;
        logic                 rsp_v;
        logic                 rsp_hit;
        logic [WORD_W-1:0]    rsp_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // request fields
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic [TAG_W-1:0]  hold_tag;
    logic [IDX_W-1:0]  hold_idx;
    logic [WSEL_W-1:0] hold_wsel;

    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx   = req_addr[OFF_W +: IDX_W];
    assign req_wsel  = req_addr[BSEL_W +: WSEL_W];
    assign hold_tag  = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign hold_idx  = ctl_q.addr[OFF_W +: IDX_W];
    assign hold_wsel = ctl_q.addr[BSEL_W +: WSEL_W];

    // way storage
    logic [1:0]              way_vld;
    logic [1:0][TAG_W-1:0]   way_tag;
    logic [1:0][LINE_W-1:0]  way_line;
    logic [1:0]              fill_en;
    logic [1:0]              upd_en;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        way_store #(
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .LINE_W (LINE_W),
            .WORD_W (WORD_W)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (req_idx),
            .rd_vld    (way_vld[w]),
            .rd_tag    (way_tag[w]),
            .rd_line   (way_line[w]),
            .fill_en   (fill_en[w]),
            .fill_idx  (hold_idx),
            .fill_tag  (hold_tag),
            .fill_line (mem_rline),
            .upd_en    (upd_en[w]),
            .upd_idx   (req_idx),
            .upd_sel   (req_wsel),
            .upd_word  (req_wdata)
        );
    end

    logic [1:0]        way_match;
    logic              lookup_hit;
    logic [WORD_W-1:0] lookup_word;
    logic              vict_way;

    tag_match #(
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W),
        .WORD_W (WORD_W)
    ) u_match (
        .way_vld  (way_vld),
        .way_tag  (way_tag),
        .way_line (way_line),
        .req_tag  (req_tag),
        .word_sel (req_wsel),
        .match    (way_match),
        .hit      (lookup_hit),
        .hit_word (lookup_word)
    );

    victim_pick u_victim (
        .way_vld (way_vld),
        .lru_way (ctl_q.lru[req_idx]),
        .victim  (vict_way)
    );

    logic accept;
    assign accept = req_valid && (ctl_q.state == ST_IDLE);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        fill_en     = '0;
        upd_en      = '0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.addr    = req_addr;
                    ctl_d.wdata   = req_wdata;
                    ctl_d.was_hit = lookup_hit;
                    ctl_d.victim  = vict_way;
                    if (lookup_hit) begin
                        // point at the way that did not hit
                        ctl_d.lru[req_idx] = way_match[0];
                    end
                    if (req_write) begin
                        upd_en      = way_match;
                        ctl_d.state = ST_WTHRU;
                    end else if (lookup_hit) begin
                        ctl_d.rsp_v    = 1'b1;
                        ctl_d.rsp_hit  = 1'b1;
                        ctl_d.rsp_data = lookup_word;
                    end else begin
                        ctl_d.state = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    fill_en[ctl_q.victim] = 1'b1;
                    ctl_d.lru[hold_idx]   = ~ctl_q.victim;
                    ctl_d.rsp_v           = 1'b1;
                    ctl_d.rsp_hit         = 1'b0;
                    ctl_d.rsp_data        = mem_rline[hold_wsel*WORD_W +: WORD_W];
                    ctl_d.state           = ST_IDLE;
                end
            end
            ST_WTHRU: begin
                if (mem_ack) begin
                    ctl_d.rsp_v    = 1'b1;
                    ctl_d.rsp_hit  = ctl_q.was_hit;
                    ctl_d.rsp_data = '0;
                    ctl_d.state    = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign resp_valid = ctl_q.rsp_v;
    assign resp_hit   = ctl_q.rsp_hit;
    assign resp_rdata = ctl_q.rsp_data;
    assign mem_req    = (ctl_q.state != ST_IDLE);
    assign mem_we     = (ctl_q.state == ST_WTHRU);
    assign mem_addr   = (ctl_q.state == ST_FILL)
                      ? {ctl_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                      : {ctl_q.addr[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}};
    assign mem_wdata  = ctl_q.wdata;

    // R4: a set never holds the same tag in both ways
    assert_no_double_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE && req_valid) |-> $onehot0(way_match));

    // R3: read hit answered on the next cycle without memory traffic
    assert_read_hit_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && lookup_hit)
        |=> (resp_valid && resp_hit && !mem_req));

    // R5: read miss turns into a line read
    assert_miss_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && !lookup_hit)
        |=> (mem_req && !mem_we));

    // R5: memory request held until acknowledged
    assert_mem_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: every accepted write goes out to memory
    assert_write_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (mem_req && mem_we));

    // R10: no acceptance while memory is busy
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

endmodule

// File: tb/sim_assoc2_cache.sv
module sim_assoc2_cache;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] JUNK_ADDR = 32'hFFFF_FF00;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid;
    logic         resp_hit;
    logic [31:0]  resp_rdata;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [31:0]  mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rline = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assoc2_cache u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_rdata (resp_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rline  (mem_rline)
    );

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int ack_cnt = 0;
    int last_ack_cyc = 0;
    bit rec_we;
    logic [31:0] rec_addr, rec_wdata;
    bit last_hit;
    logic [31:0] mem_over [int unsigned];

    // reference cache state
    bit          rv [2][64];
    logic [21:0] rt [2][64];
    bit          rl [64];

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        logic [31:0] wa;
        wa = {a[31:2], 2'b00};
        if (mem_over.exists(wa)) return mem_over[wa];
        return (wa * 32'h9E37_79B1) ^ 32'h1357_9BDF;
    endfunction

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // memory responder with random latency
    initial begin
        bit pend;
        int lat;
        pend = 0;
        lat = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (!pend) begin
                    pend = 1;
                    lat = $urandom_range(0, 3);
                end
                if (lat == 0) begin
                    pend = 0;
                    rec_we = mem_we;
                    rec_addr = mem_addr;
                    rec_wdata = mem_wdata;
                    if (mem_we) begin
                        mem_over[{mem_addr[31:2], 2'b00}] = mem_wdata;
                    end else begin
                        for (int k = 0; k < 4; k++) begin
                            mem_rline[k*32 +: 32] = mem_rd({mem_addr[31:4], 4'(k*4)});
                        end
                    end
                    mem_ack = 1'b1;
                    ack_cnt++;
                    last_ack_cyc = cyc;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic do_access(input bit wr, input logic [31:0] a, input logic [31:0] wd, input bit junk);
        logic [5:0]  idx;
        logic [21:0] tg;
        bit m0, m1, ehit, got, v;
        logic [31:0] edata;
        int c0, a0;
        idx = a[9:4];
        tg = a[31:10];
        m0 = rv[0][idx] && rt[0][idx] == tg;
        m1 = rv[1][idx] && rt[1][idx] == tg;
        ehit = m0 || m1;
        edata = mem_rd(a);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr = a;
        req_wdata = wd;
        c0 = cyc;
        a0 = ack_cnt;
        got = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (resp_valid) begin
                got = 1;
                req_valid = 1'b0;
                break;
            end
            if (junk) begin
                chk(req_ready == 1'b0, "R10 ready while busy", 32'(req_ready), 32'd0);
                req_valid = 1'b1;
                req_write = 1'b1;
                req_addr = JUNK_ADDR;
                req_wdata = 32'hDEAD_BEEF;
            end else begin
                req_valid = 1'b0;
            end
        end
        chk(got, "R5 response arrives", 32'(got), 32'd1);
        if (!wr && ehit) begin
            chk(cyc == c0 + 1, "R3 hit latency", 32'(cyc - c0), 32'd1);
            chk(ack_cnt == a0, "R3 no memory access", 32'(ack_cnt - a0), 32'd0);
            chk(resp_hit == 1'b1, "R3 hit flag", 32'(resp_hit), 32'd1);
            chk(resp_rdata == edata, "R3 hit data", resp_rdata, edata);
        end else begin
            chk(ack_cnt == a0 + 1, "R5 one memory transaction", 32'(ack_cnt - a0), 32'd1);
            chk(cyc == last_ack_cyc + 1, "R5 response after ack", 32'(cyc - last_ack_cyc), 32'd1);
            if (!wr) begin
                chk(rec_we == 1'b0, "R5 read op", 32'(rec_we), 32'd0);
                chk(rec_addr == {a[31:4], 4'h0}, "R5 line address", rec_addr, {a[31:4], 4'h0});
                chk(resp_hit == 1'b0, "R5 miss flag", 32'(resp_hit), 32'd0);
                chk(resp_rdata == edata, "R5 refill data", resp_rdata, edata);
            end else begin
                chk(rec_we == 1'b1, "R8 write op", 32'(rec_we), 32'd1);
                chk(rec_addr == {a[31:2], 2'b00}, "R8 write address", rec_addr, {a[31:2], 2'b00});
                chk(rec_wdata == wd, "R8 write data", rec_wdata, wd);
                chk(resp_hit == ehit, ehit ? "R8 write hit flag" : "R9 write miss flag",
                    32'(resp_hit), 32'(ehit));
            end
        end
        last_hit = resp_hit;
        // update reference: R6 victim choice, R7 LRU points away from last use
        if (ehit) begin
            rl[idx] = m0;
        end else if (!wr) begin
            if (!rv[0][idx]) v = 0;
            else if (!rv[1][idx]) v = 1;
            else v = rl[idx];
            rv[v][idx] = 1;
            rt[v][idx] = tg;
            rl[idx] = ~v;
        end
    endtask

    function automatic logic [31:0] mk(input logic [21:0] tg, input logic [5:0] idx,
                                       input logic [1:0] w, input logic [1:0] b);
        return {tg, idx, w, b};
    endfunction

    task automatic expect_hit(input bit e, input string r);
        chk(last_hit == e, r, 32'(last_hit), 32'(e));
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed_init;
        logic [31:0] a;
        seed_init = $urandom(32'd4711);
        for (int s = 0; s < 64; s++) begin
            rv[0][s] = 0; rv[1][s] = 0; rl[s] = 0;
            rt[0][s] = '0; rt[1][s] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(req_ready == 1'b1, "R2 ready after reset", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R2 no response after reset", 32'(resp_valid), 32'd0);
        chk(mem_req == 1'b0, "R2 no memory request after reset", 32'(mem_req), 32'd0);

        // R2 first access misses; R1 word select and ignored byte bits
        do_access(0, mk(22'd1, 6'd5, 2'd2, 2'd3), '0, 0);
        expect_hit(0, "R2 first read misses");
        do_access(0, mk(22'd1, 6'd5, 2'd1, 2'd0), '0, 0);
        expect_hit(1, "R1 other word of same line hits");
        // R6 second tag fills the empty way; R4 both coexist
        do_access(0, mk(22'd2, 6'd5, 2'd0, 2'd1), '0, 0);
        expect_hit(0, "R6 second tag misses");
        do_access(0, mk(22'd1, 6'd5, 2'd3, 2'd0), '0, 0);
        expect_hit(1, "R4 first tag still hits");
        do_access(0, mk(22'd2, 6'd5, 2'd3, 2'd2), '0, 0);
        expect_hit(1, "R4 second tag still hits");
        // R7: touch tag1 so tag2 becomes the victim
        do_access(0, mk(22'd1, 6'd5, 2'd0, 2'd0), '0, 0);
        do_access(0, mk(22'd3, 6'd5, 2'd0, 2'd0), '0, 0);
        expect_hit(0, "R6 third tag misses");
        do_access(0, mk(22'd1, 6'd5, 2'd2, 2'd0), '0, 0);
        expect_hit(1, "R7 recently used line kept");
        do_access(0, mk(22'd2, 6'd5, 2'd2, 2'd0), '0, 0);
        expect_hit(0, "R7 least recently used line evicted");
        // R8 write hit then read back
        do_access(1, mk(22'd1, 6'd5, 2'd0, 2'd2), 32'hCAFE_0001, 0);
        expect_hit(1, "R8 write hit");
        do_access(0, mk(22'd1, 6'd5, 2'd0, 2'd0), '0, 0);
        expect_hit(1, "R8 read after write hit");
        chk(resp_rdata == 32'hCAFE_0001, "R8 updated word", resp_rdata, 32'hCAFE_0001);
        // R9 write miss does not allocate
        do_access(1, mk(22'd9, 6'd7, 2'd1, 2'd0), 32'h1234_5678, 0);
        expect_hit(0, "R9 write miss");
        do_access(0, mk(22'd9, 6'd7, 2'd1, 2'd0), '0, 0);
        expect_hit(0, "R9 no allocation on write miss");
        chk(resp_rdata == 32'h1234_5678, "R9 memory took the write", resp_rdata, 32'h1234_5678);
        // R10 requests during a miss are ignored
        do_access(0, mk(22'd4, 6'd9, 2'd0, 2'd0), '0, 1);
        chk(!mem_over.exists(JUNK_ADDR), "R10 ignored write not forwarded", 32'd0, 32'd0);
        do_access(0, JUNK_ADDR, '0, 0);
        expect_hit(0, "R10 ignored request not allocated");
        // R1 tags differing only in bit 31 do not alias
        do_access(0, mk(22'h1FFFFF, 6'd11, 2'd0, 2'd0), '0, 0);
        do_access(0, mk(22'h3FFFFF, 6'd11, 2'd0, 2'd0), '0, 0);
        expect_hit(0, "R1 top tag bit distinguishes lines");

        // constrained random traffic
        for (int n = 0; n < 600; n++) begin
            logic [21:0] tg;
            int pick;
            pick = $urandom_range(0, 3);
            tg = (pick == 3) ? 22'h3FFFFF : 22'(pick);
            a = mk(tg, 6'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
            do_access(1'($urandom_range(0, 3) == 0), a, $urandom, 1'($urandom_range(0, 7) == 0));
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule